// File: doc/BRIEF.md
# Capability Load/Store Permission Filter

This block sits on the path between a capability register file and memory. It applies the tag and permission rules that hold when a capability is copied through memory. It does not raise faults. On a store it works out whether the tag written to memory survives. The tag survives only when the authorising capability may store local capabilities or when the value being stored is global. On a load it reduces the permissions of a tagged capability that was fetched through an authority without load-mutable rights. The reduced permissions are written back into a compact 6-bit permission code.

The 6-bit permission code is dense, and its format is told apart by fixed bits. This block understands one format in full: the read/write capability format. Bits 4 and 3 are both 1 in that format. A capability in this format implicitly holds load, memory-capability and store rights. The other four bits each grant one right when set: bit 0 is invalid-level-grant (ILG), bit 1 is load-mutable, bit 2 is store-local and bit 5 is global. In every format, bit 5 is the global flag. Codes in any other format are carried through unchanged. An authority in any other format is treated as holding none of the rights decoded here.

A request enters with `in_valid` and is presented registered one cycle later. The reserved bit and the remaining capability payload are never altered.

Top module: `cap_perm_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_tag` are 0 after that edge.
- R2: Each request with `in_valid` high at a clock edge produces `out_valid` high after that same edge, with its results on the outputs.
- R3: A permission code with bits [4:3] = 2'b11 decodes as load, memory-capability and store granted, plus ILG = bit 0, load-mutable = bit 1, store-local = bit 2 and global = bit 5. Any other code grants none of these except global = bit 5.
- R4: On a store (`in_store`=1), a tagged value whose permission bit 5 (global) is 1 keeps its tag.
- R5: On a store, a tagged value with bit 5 clear keeps its tag only if the authority code has bits [4:3] = 2'b11 and bit 2 (store-local) = 1. Otherwise `out_tag` is 0. An untagged value always gives `out_tag` 0.
- R6: On a store, `out_perms` equals `cap_perms` unchanged.
- R7: On a load (`in_store`=0) through an authority with bits [4:3] = 2'b11 and bit 1 = 1, the loaded code is decoded and re-encoded with no loss. `out_perms` equals `cap_perms`.
- R8: On a load, a tagged read/write-format code fetched through an authority without load-mutable (per R3) loses store, store-local and load-mutable. It is re-encoded in the read-only format {bit5 = global, bits[4:3] = 2'b10, bits[2:1] = 2'b00, bit0 = ILG}.
- R9: On a load, an untagged value, or a code whose bits [4:3] are not 2'b11, passes through with `out_perms` equal to `cap_perms`.
- R10: `out_rsv` and `out_rest` always equal the request's `cap_rsv` and `cap_rest`. On a load, `out_tag` equals `cap_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_store | input | 1 | 1 = store, 0 = load |
| auth_perms | input | 6 | Permission code of the authorising capability |
| cap_tag | input | 1 | Tag of the value being moved |
| cap_rsv | input | 1 | Reserved bit of the value being moved |
| cap_perms | input | 6 | Permission code of the value being moved |
| cap_rest | input | REST_W | Remaining capability bits (bounds, type, address) |
| out_valid | output | 1 | Result present |
| out_tag | output | 1 | Resulting tag |
| out_rsv | output | 1 | Resulting reserved bit |
| out_perms | output | 6 | Resulting permission code |
| out_rest | output | REST_W | Resulting remaining bits |

## Verification
Every result is due exactly one clock edge after the edge that samples the request. No result is due in the same cycle as its request and none later than that one edge. The bench drives each request on a falling edge. It waits for the next rising edge and samples all outputs a nanosecond after it. The expected tag and permission code come from bench functions written directly from R3 to R10. Random requests are mixed with directed cases for local stores, load-mutable stripping and foreign formats.

// File: rtl/cap_perm_pkg.sv
package cap_perm_pkg;

    localparam int PERM_W = 6;
    localparam logic [1:0] FMT_RW = 2'b11;   // read/write capability format id
    localparam logic [1:0] FMT_RO = 2'b10;   // read-only capability format id

    typedef struct packed {
        logic gl;    // global
        logic ld;    // load
        logic mc;    // memory-capability
        logic sd;    // store
        logic sl;    // store-local
        logic lm;    // load-mutable
        logic ilg;   // invalid-level-grant
    } arch_perm_t;

    function automatic logic fmt_is_rw(input logic [PERM_W-1:0] code);
        return code[4:3] == FMT_RW;
    endfunction

    function automatic arch_perm_t perm_unpack(input logic [PERM_W-1:0] code);
        arch_perm_t p;
        p = '0;
        p.gl = code[5];
        if (fmt_is_rw(code)) begin
            p.ld  = 1'b1;
            p.mc  = 1'b1;
            p.sd  = 1'b1;
            p.sl  = code[2];
            p.lm  = code[1];
            p.ilg = code[0];
        end
        return p;
    endfunction

    function automatic logic [PERM_W-1:0] perm_pack(input arch_perm_t p);
        if (p.sd)
            return {p.gl, FMT_RW, p.sl, p.lm, p.ilg};
        else
            return {p.gl, FMT_RO, 1'b0, p.lm, p.ilg};
    endfunction

endpackage

// File: rtl/cap_perm_decode.sv
module cap_perm_decode
    import cap_perm_pkg::*;
(
    input  logic [PERM_W-1:0] code,
    output arch_perm_t        perms,
    output logic              is_rw
);
    always_comb begin
        perms = perm_unpack(code);
        is_rw = fmt_is_rw(code);
    end
endmodule

// File: rtl/cap_store_rule.sv
module cap_store_rule
    import cap_perm_pkg::*;
(
    input  arch_perm_t auth,
    input  logic       auth_rw,
    input  logic       cap_tag,
    input  logic       cap_global,
    output logic       keep_tag
);
    logic may_store_local;

    always_comb begin
        may_store_local = auth_rw && auth.sl && auth.sd && auth.mc;
        keep_tag        = cap_tag && (cap_global || may_store_local);
    end
endmodule

// File: rtl/cap_load_rule.sv
module cap_load_rule
    import cap_perm_pkg::*;
(
    input  arch_perm_t        auth,
    input  logic              auth_rw,
    input  logic              cap_tag,
    input  logic              cap_rw,
    input  arch_perm_t        cap_p,
    input  logic [PERM_W-1:0] cap_code,
    output logic [PERM_W-1:0] new_code
);
    arch_perm_t reduced;
    logic       strip;

    always_comb begin
        strip   = !(auth_rw && auth.lm);
        reduced = cap_p;
        if (strip) begin
            reduced.sd = 1'b0;
            reduced.sl = 1'b0;
            reduced.lm = 1'b0;
        end
        if (cap_tag && cap_rw)
            new_code = perm_pack(reduced);
        else
            new_code = cap_code;
    end
endmodule

// File: rtl/cap_perm_filter.sv
module cap_perm_filter
    import cap_perm_pkg::*;
#(
    parameter int REST_W = 56
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_store,
    input  logic [5:0]        auth_perms,
    input  logic              cap_tag,
    input  logic              cap_rsv,
    input  logic [5:0]        cap_perms,
    input  logic [REST_W-1:0] cap_rest,
    output logic              out_valid,
    output logic              out_tag,
    output logic              out_rsv,
    output logic [5:0]        out_perms,
    output logic [REST_W-1:0] out_rest
);
    arch_perm_t        auth_p, cap_p;
    logic              auth_rw, cap_rw;
    logic              st_tag;
    logic [PERM_W-1:0] ld_code;

    cap_perm_decode u_dec_auth (.code(auth_perms), .perms(auth_p), .is_rw(auth_rw));
    cap_perm_decode u_dec_cap  (.code(cap_perms),  .perms(cap_p),  .is_rw(cap_rw));

    cap_store_rule u_store (
        .auth(auth_p), .auth_rw(auth_rw), .cap_tag(cap_tag),
        .cap_global(cap_p.gl), .keep_tag(st_tag)
    );

    cap_load_rule u_load (
        .auth(auth_p), .auth_rw(auth_rw), .cap_tag(cap_tag), .cap_rw(cap_rw),
        .cap_p(cap_p), .cap_code(cap_perms), .new_code(ld_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tag   <= 1'b0;
            out_rsv   <= 1'b0;
            out_perms <= '0;
            out_rest  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_tag   <= in_store ? st_tag : cap_tag;
                out_perms <= in_store ? cap_perms : ld_code;
                out_rsv   <= cap_rsv;
                out_rest  <= cap_rest;
            end
        end
    end

    // R1
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!out_valid && !out_tag));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_store_global_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_store && cap_tag && cap_perms[5]) |=> out_tag);

    p_store_untagged_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_store && !cap_tag) |=> !out_tag);

    p_store_perms_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_store) |=> (out_perms == $past(cap_perms)));

    p_load_mutable_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_store && auth_perms[4:3] == 2'b11 && auth_perms[1])
        |=> (out_perms == $past(cap_perms)));

    p_load_strip_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_store && cap_tag && cap_perms[4:3] == 2'b11 &&
         !(auth_perms[4:3] == 2'b11 && auth_perms[1]))
        |=> (out_perms[4:1] == 4'b1000));

    p_keep_fields_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_rsv == $past(cap_rsv) && out_rest == $past(cap_rest)));

    p_load_tag_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_store) |=> (out_tag == $past(cap_tag)));

endmodule

// File: tb/cap_perm_filter_test.sv
module cap_perm_filter_test;
    localparam int REST_W = 56;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid, in_store, cap_tag, cap_rsv;
    logic [5:0]        auth_perms, cap_perms;
    logic [REST_W-1:0] cap_rest;
    logic              out_valid, out_tag, out_rsv;
    logic [5:0]        out_perms;
    logic [REST_W-1:0] out_rest;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    cap_perm_filter #(.REST_W(REST_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_store(in_store),
        .auth_perms(auth_perms), .cap_tag(cap_tag), .cap_rsv(cap_rsv),
        .cap_perms(cap_perms), .cap_rest(cap_rest),
        .out_valid(out_valid), .out_tag(out_tag), .out_rsv(out_rsv),
        .out_perms(out_perms), .out_rest(out_rest)
    );

    function automatic bit auth_rw_lm(input logic [5:0] a);
        return (a[4:3] == 2'b11) && a[1];
    endfunction

    function automatic logic exp_tag(input logic st, input logic [5:0] a,
                                     input logic t, input logic [5:0] c);
        if (!st) return t;
        return t && (c[5] || (a[4:3] == 2'b11 && a[2]));
    endfunction

    function automatic logic [5:0] exp_perms(input logic st, input logic [5:0] a,
                                             input logic t, input logic [5:0] c);
        if (st) return c;
        if (t && c[4:3] == 2'b11 && !auth_rw_lm(a))
            return {c[5], 2'b10, 2'b00, c[0]};
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic st, input logic [5:0] a, input logic t,
                         input logic r, input logic [5:0] c, input logic [REST_W-1:0] rest,
                         input string req);
        @(negedge clk);
        in_valid = 1'b1; in_store = st; auth_perms = a;
        cap_tag = t; cap_rsv = r; cap_perms = c; cap_rest = rest;
        @(posedge clk);
        #1;
        check({"R2 ", req}, {63'd0, out_valid}, 64'd1);
        check({req, " tag"}, {63'd0, out_tag}, {63'd0, exp_tag(st, a, t, c)});
        check({req, " perms"}, {58'd0, out_perms}, {58'd0, exp_perms(st, a, t, c)});
        check("R10 rsv", {63'd0, out_rsv}, {63'd0, r});
        check("R10 rest", {8'd0, out_rest}, {8'd0, rest});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst = 1'b1; in_valid = 1'b0; in_store = 1'b0; auth_perms = '0;
        cap_tag = 1'b0; cap_rsv = 1'b0; cap_perms = '0; cap_rest = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 tag", {63'd0, out_tag}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R2 idle", {63'd0, out_valid}, 64'd0);

        // R4: global value stored through authority with no store-local
        apply(1'b1, 6'b011000, 1'b1, 1'b0, 6'b111000, 56'h12345, "R4");
        // R5: local value, authority with store-local keeps tag
        apply(1'b1, 6'b011100, 1'b1, 1'b1, 6'b011011, 56'hABCDE, "R5 sl");
        // R5: local value, authority lacking store-local strips tag
        apply(1'b1, 6'b111011, 1'b1, 1'b0, 6'b011111, 56'h1, "R5 nosl");
        // R5: authority in a foreign format grants no store-local
        apply(1'b1, 6'b000111, 1'b1, 1'b0, 6'b011100, 56'h2, "R5 foreign");
        // R5 / R6: untagged store
        apply(1'b1, 6'b011100, 1'b0, 1'b1, 6'b101010, 56'h3, "R6 untag");
        // R7 / R3: round trip of every read/write code through a load-mutable authority
        for (int i = 0; i < 16; i++) begin
            logic [5:0] c;
            c = {i[3], 2'b11, i[2:0]};
            apply(1'b0, 6'b011010, 1'b1, i[0], c, 56'(i * 77), "R7 R3");
        end
        // R8: load-mutable missing
        apply(1'b0, 6'b011101, 1'b1, 1'b0, 6'b111111, 56'h4, "R8 gl");
        apply(1'b0, 6'b011000, 1'b1, 1'b1, 6'b011110, 56'h5, "R8 local");
        apply(1'b0, 6'b100110, 1'b1, 1'b0, 6'b011011, 56'h6, "R8 foreign auth");
        // R9: untagged and foreign-format loads pass through
        apply(1'b0, 6'b011000, 1'b0, 1'b1, 6'b011111, 56'h7, "R9 untag");
        apply(1'b0, 6'b011000, 1'b1, 1'b0, 6'b101101, 56'h8, "R9 foreign");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [5:0] a, c;
            logic st;
            a  = 6'($urandom);
            c  = 6'($urandom);
            if ($urandom % 2) a[4:3] = 2'b11;
            if ($urandom % 2) c[4:3] = 2'b11;
            st = 1'($urandom);
            apply(st, a, 1'($urandom), 1'($urandom), c,
                  {24'($urandom), 32'($urandom)}, st ? "R5 rnd" : "R8 rnd");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule